// File: doc/BRIEF.md
# Emulated UART Receive Status Path

This block is the receive half of a UART register set that two agents share. A local micro-controller plays the role of the serial line. It writes received bytes into the block and injects their error status through a separate status write. A host then reads the bytes and the line status as it would on an ordinary 16450 or 16550 style UART. A mode input selects single-register behaviour or a 16-entry receive FIFO.

Error status does not go onto the line directly. A status write (parity, framing, break) parks the bits in a shadow field. The next data write attaches them to that byte and clears the shadow. The host sees a byte's error bits when that byte is at the head of the buffer. Errors from bytes it has already read stay reported until it reads the line status. The host's data-ready flag can be held back by a programmable delay timer. The micro-controller has its own data-ready output, which is never delayed.

Top module: `uart_rx_status`

## Requirements
- R1: A status write (`ucLsrWr`) changes nothing in `hostLsr[4:2]` until a data byte is written. Field mapping: `ucLsrErr[0]` is parity and appears at `hostLsr[2]`. `ucLsrErr[1]` is framing and appears at `hostLsr[3]`. `ucLsrErr[2]` is break and appears at `hostLsr[4]`.
- R2: An accepted data write stores the current shadow status with the byte. Any data write clears the shadow, so the next byte carries no status unless a new status write comes first.
- R3: While the buffer holds data, `hostLsr[4:2]` shows the status of the head byte. It also shows the OR of the status of every byte the host has read since its last line-status read.
- R4: A host line-status read (`hostLsrRd`) clears the accumulated error bits in the following cycle. The head byte's own status stays visible.
- R5: In FIFO mode (`fifoMode`=1), `hostLsr[7]` is 1 from the cycle after a byte with nonzero status is stored. It returns to 0 once no stored byte has nonzero status. In single mode it is always 0.
- R6: In single mode (`fifoMode`=0), a data write while a byte is unread sets overrun (`hostLsr[1]`). The new byte is discarded and the stored byte is kept.
- R7: In FIFO mode, 16 bytes are accepted without overrun. A data write to a full FIFO sets overrun and the byte is discarded.
- R8: The overrun bit clears in the cycle after a host line-status read, unless a new overrun occurs in the same cycle.
- R9: With the timer disabled (`timerEn`=0), `hostLsr[0]` is 1 in the cycle after a data write into an empty buffer.
- R10: With the timer enabled and `timerLoad`=N>0, `hostLsr[0]` rises N cycles after `ucDataReady`. Each accepted data write restarts the N-cycle count.
- R11: `ucDataReady` is 1 in the cycle after any accepted data write, whatever the timer setting. Both `ucDataReady` and `hostLsr[0]` fall in the cycle after the host reads the last stored byte.
- R12: After reset, `hostLsr` is 0 and `ucDataReady` is 0. Bits 6 and 5 of `hostLsr` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoMode | input | 1 | 1 = 16-entry FIFO, 0 = single register |
| timerEn | input | 1 | Enables the host data-ready delay |
| timerLoad | input | TW | Delay in clock cycles |
| ucDataWr | input | 1 | Micro-controller data write strobe |
| ucData | input | 8 | Byte being written |
| ucLsrWr | input | 1 | Micro-controller status write strobe |
| ucLsrErr | input | 3 | {break, framing, parity} for the next byte |
| ucDataReady | output | 1 | Undelayed data-ready flag for the micro-controller |
| hostDataRd | input | 1 | Host reads (pops) the head byte |
| hostLsrRd | input | 1 | Host reads the line status |
| hostData | output | 8 | Head byte, 0 when empty |
| hostLsr | output | 8 | Host line status |

## Verification
The assertions take `fifoMode` as fixed between resets. They also take `timerLoad` as stable while a delay is counting, because the delay and capacity properties measure against those values. The stimulus changes the mode only inside a reset sequence and sets `timerLoad` before enabling the timer. Every strobe is driven for exactly one cycle on the falling edge, so each read or write is a single event.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  localparam int ERR_W  = 3;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef struct packed {
    logic push;
    logic pop;
  } rx_strobe_t;
endpackage

// File: rtl/uart_rx_status_dpath.sv
module uart_rx_status_dpath
  import uart_rx_status_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  rx_strobe_t  strobe,
  input  rx_entry_t   wrEntry,
  output rx_entry_t   headEntry,
  output logic [CW-1:0] level,
  output logic        errPresent
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  rx_entry_t     store [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] errCnt;
  logic          pushErr, popErr;

  assign pushErr = strobe.push && (wrEntry.err != '0);
  assign popErr  = strobe.pop && (store[rdPtr].err != '0);

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      errCnt <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + AW'(1);
      if (strobe.pop)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + AW'(1);
      level  <= level + CW'(strobe.push) - CW'(strobe.pop);
      errCnt <= errCnt + CW'(pushErr) - CW'(popErr);
    end
  end

  assign headEntry  = store[rdPtr];
  assign errPresent = (errCnt != '0);
endmodule

// File: rtl/uart_rx_status_ctrl.sv
module uart_rx_status_ctrl
  import uart_rx_status_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TW = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic              timerEn,
  input  logic [TW-1:0]     timerLoad,
  input  logic              ucDataWr,
  input  logic [DATA_W-1:0] ucData,
  input  logic              ucLsrWr,
  input  logic [ERR_W-1:0]  ucLsrErr,
  input  logic              hostDataRd,
  input  logic              hostLsrRd,
  input  logic [CW-1:0]     level,
  input  rx_entry_t         headEntry,
  input  logic              errPresent,
  output rx_strobe_t        strobe,
  output rx_entry_t         wrEntry,
  output logic              ucDataReady,
  output logic [7:0]        hostLsr
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [ERR_W-1:0] shadowErr;
  logic [ERR_W-1:0] lsrErr;
  logic             overrun;
  logic [TW-1:0]    timer;
  logic             drHeld;
  logic             full, notEmpty, hostDr;
  logic [CW-1:0]    levelNext;
  logic [ERR_W-1:0] headErr;

  assign notEmpty  = (level != '0);
  assign full      = fifoMode ? (level == FULL_LVL) : notEmpty;
  assign strobe.push = ucDataWr && !full;
  assign strobe.pop  = hostDataRd && notEmpty;
  assign wrEntry   = '{err: shadowErr, data: ucData};
  assign levelNext = level + CW'(strobe.push) - CW'(strobe.pop);
  assign headErr   = notEmpty ? headEntry.err : '0;

  // status staged until the next data byte
  always_ff @(posedge clk) begin
    if (!rstN)          shadowErr <= '0;
    else if (ucLsrWr)   shadowErr <= ucLsrErr;
    else if (ucDataWr)  shadowErr <= '0;
  end

  // accumulated error bits and overrun
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lsrErr  <= '0;
      overrun <= 1'b0;
    end else begin
      lsrErr <= (hostLsrRd ? '0 : lsrErr) | (strobe.pop ? headEntry.err : '0);
      if (ucDataWr && full) overrun <= 1'b1;
      else if (hostLsrRd)   overrun <= 1'b0;
    end
  end

  // host data-ready delay
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer  <= '0;
      drHeld <= 1'b0;
    end else begin
      if (strobe.push)        timer <= timerLoad;
      else if (timer != '0)   timer <= timer - TW'(1);

      if (levelNext == '0)                           drHeld <= 1'b0;
      else if (strobe.push && timerLoad == '0)       drHeld <= 1'b1;
      else if (timer == TW'(1))                      drHeld <= 1'b1;
    end
  end

  assign hostDr      = timerEn ? drHeld : notEmpty;
  assign ucDataReady = notEmpty;
  assign hostLsr     = {fifoMode & errPresent, 2'b00, lsrErr | headErr, overrun, hostDr};
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TW = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoMode,
  input  logic          timerEn,
  input  logic [TW-1:0] timerLoad,
  input  logic          ucDataWr,
  input  logic [7:0]    ucData,
  input  logic          ucLsrWr,
  input  logic [2:0]    ucLsrErr,
  output logic          ucDataReady,
  input  logic          hostDataRd,
  input  logic          hostLsrRd,
  output logic [7:0]    hostData,
  output logic [7:0]    hostLsr
);
  rx_strobe_t    strobe;
  rx_entry_t     wrEntry, headEntry;
  logic [CW-1:0] level;
  logic          errPresent;

  uart_rx_status_ctrl #(.DEPTH(DEPTH), .TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .timerEn(timerEn),
    .timerLoad(timerLoad), .ucDataWr(ucDataWr), .ucData(ucData),
    .ucLsrWr(ucLsrWr), .ucLsrErr(ucLsrErr), .hostDataRd(hostDataRd),
    .hostLsrRd(hostLsrRd), .level(level), .headEntry(headEntry),
    .errPresent(errPresent), .strobe(strobe), .wrEntry(wrEntry),
    .ucDataReady(ucDataReady), .hostLsr(hostLsr)
  );

  uart_rx_status_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEntry(wrEntry),
    .headEntry(headEntry), .level(level), .errPresent(errPresent)
  );

  assign hostData = (level != '0) ? headEntry.data : '0;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DEPTH = 16,
  parameter int TW = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          fifoMode,
  input logic          timerEn,
  input logic [TW-1:0] timerLoad,
  input logic          ucDataWr,
  input logic          ucDataReady,
  input logic          hostDataRd,
  input logic          hostLsrRd,
  input logic [7:0]    hostLsr,
  input logic [CW-1:0] level
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  p_fifo_err_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    !fifoMode |-> !hostLsr[7]);

  p_single_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fifoMode |-> (level <= CW'(1)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL);

  p_ovr_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostLsrRd && !ucDataWr) |=> !hostLsr[1]);

  p_dr_prompt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && ucDataWr && level == '0) |=> hostLsr[0]);

  p_dr_delay_r10: assert property (@(posedge clk) disable iff (!rstN)
    (timerEn && ucDataWr && level == '0 && timerLoad != '0) |=> (!hostLsr[0] && ucDataReady));

  p_host_needs_shadow_r11: assert property (@(posedge clk) disable iff (!rstN)
    hostLsr[0] |-> ucDataReady);

  p_empty_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (level == CW'(1) && hostDataRd && !ucDataWr) |=> (!ucDataReady && !hostLsr[0]));

  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    hostLsr[6:5] == 2'b00);
endmodule

bind uart_rx_status uart_rx_status_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .timerEn(timerEn),
  .timerLoad(timerLoad), .ucDataWr(ucDataWr), .ucDataReady(ucDataReady),
  .hostDataRd(hostDataRd), .hostLsrRd(hostLsrRd), .hostLsr(hostLsr),
  .level(level)
);

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/100ps
module uart_rx_status_bench;
  localparam int DEPTH = 16;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fifoMode = 1'b0;
  logic          timerEn = 1'b0;
  logic [TW-1:0] timerLoad = '0;
  logic          ucDataWr = 1'b0;
  logic [7:0]    ucData = '0;
  logic          ucLsrWr = 1'b0;
  logic [2:0]    ucLsrErr = '0;
  logic          ucDataReady;
  logic          hostDataRd = 1'b0;
  logic          hostLsrRd = 1'b0;
  logic [7:0]    hostData;
  logic [7:0]    hostLsr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [10:0] expQ[$];
  logic [2:0]  expShadow = '0;

  always #2.5 clk = ~clk;

  uart_rx_status #(.DEPTH(DEPTH), .TW(TW)) u_uart_rx_status (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN = 1'b0; fifoMode = mode;
    expQ.delete(); expShadow = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic ucStatus(input logic [2:0] s);
    @(negedge clk); ucLsrWr = 1'b1; ucLsrErr = s;
    @(negedge clk); ucLsrWr = 1'b0;
    expShadow = s;
  endtask

  // driver: model acceptance and push the expected entry
  task automatic ucWrite(input logic [7:0] d);
    int cap;
    cap = fifoMode ? DEPTH : 1;
    @(negedge clk); ucDataWr = 1'b1; ucData = d;
    if (expQ.size() < cap) expQ.push_back({expShadow, d});
    expShadow = '0;
    @(negedge clk); ucDataWr = 1'b0;
  endtask

  task automatic hostRead();
    @(negedge clk); hostDataRd = 1'b1;
    @(negedge clk); hostDataRd = 1'b0;
  endtask

  task automatic lsrRead();
    @(negedge clk); hostLsrRd = 1'b1;
    @(negedge clk); hostLsrRd = 1'b0;
  endtask

  // monitor: compare head byte and its status on each host read
  always @(negedge clk) begin
    #1;
    if (hostDataRd && rstN) begin
      if (expQ.size() == 0) chk("R11 read with empty model", 32'(ucDataReady), 32'd0);
      else begin
        logic [10:0] e;
        e = expQ.pop_front();
        chk("R2 head data", 32'(hostData), 32'(e[7:0]));
        chk("R3 head status visible", 32'(hostLsr[4:2] & e[10:8]), 32'(e[10:8]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset(1'b0);
    #1;
    chk("R12 reset lsr", 32'(hostLsr), 32'd0);
    chk("R12 reset uc ready", 32'(ucDataReady), 32'd0);

    // single mode
    ucStatus(3'b001);
    chk("R1 shadow hidden", 32'(hostLsr[4:2]), 32'd0);
    ucWrite(8'hA5);
    chk("R9 ready at once", 32'(hostLsr[0]), 32'd1);
    chk("R2 status attached", 32'(hostLsr[4:2]), 32'd1);
    chk("R5 single mode no fifo err", 32'(hostLsr[7]), 32'd0);
    ucWrite(8'h3C);
    chk("R6 overrun set", 32'(hostLsr[1]), 32'd1);
    chk("R6 first byte kept", 32'(hostData), 32'hA5);
    lsrRead();
    chk("R8 overrun cleared", 32'(hostLsr[1]), 32'd0);
    hostRead();
    chk("R3 error kept after read", 32'(hostLsr[4:2]), 32'd1);
    chk("R11 host ready falls", 32'(hostLsr[0]), 32'd0);
    chk("R11 uc ready falls", 32'(ucDataReady), 32'd0);
    lsrRead();
    chk("R4 lsr read clears errors", 32'(hostLsr[4:2]), 32'd0);
    ucWrite(8'h11);
    chk("R2 shadow auto cleared", 32'(hostLsr[4:2]), 32'd0);
    hostRead();

    // fifo mode, head-only visibility
    doReset(1'b1);
    ucWrite(8'h01);
    ucStatus(3'b010);
    ucWrite(8'h02);
    ucWrite(8'h03);
    chk("R5 fifo error present", 32'(hostLsr[7]), 32'd1);
    chk("R3 clean head hides later error", 32'(hostLsr[4:2]), 32'd0);
    hostRead();
    chk("R3 error at head", 32'(hostLsr[4:2]), 32'b010);
    hostRead();
    chk("R3 accumulated error", 32'(hostLsr[4:2]), 32'b010);
    chk("R5 fifo error gone", 32'(hostLsr[7]), 32'd0);
    lsrRead();
    chk("R4 accumulated cleared", 32'(hostLsr[4:2]), 32'd0);
    hostRead();

    // fill to capacity
    for (int i = 0; i < DEPTH; i++) ucWrite(8'(8'h40 + i));
    chk("R7 full without overrun", 32'(hostLsr[1]), 32'd0);
    ucWrite(8'hEE);
    chk("R7 overrun on full", 32'(hostLsr[1]), 32'd1);
    for (int i = 0; i < DEPTH; i++) hostRead();
    chk("R7 extra byte discarded", 32'(ucDataReady), 32'd0);
    lsrRead();

    // delay timer
    doReset(1'b1);
    timerLoad = TW'(8);
    timerEn = 1'b1;
    ucWrite(8'h77);
    chk("R11 uc ready undelayed", 32'(ucDataReady), 32'd1);
    chk("R10 host ready held", 32'(hostLsr[0]), 32'd0);
    repeat (7) @(negedge clk);
    #1 chk("R10 one cycle before expiry", 32'(hostLsr[0]), 32'd0);
    @(negedge clk);
    #1 chk("R10 ready after interval", 32'(hostLsr[0]), 32'd1);
    hostRead();
    ucWrite(8'h78);
    repeat (4) @(negedge clk);
    ucWrite(8'h79);
    repeat (7) @(negedge clk);
    #1 chk("R10 restart delays ready", 32'(hostLsr[0]), 32'd0);
    @(negedge clk);
    #1 chk("R10 ready after restart", 32'(hostLsr[0]), 32'd1);
    hostRead();
    hostRead();
    chk("R11 all read clears", 32'(hostLsr[0]), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule